// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block decides which of several DMA channels is served next and runs the bus-ownership handshake with the host processor. Each channel has two request sources. One is a hardware request line whose active level is programmable. The other is a software request bit held inside the block. A per-channel mask bit blocks the hardware line but has no effect on the software bit. When at least one qualified request exists, the block raises a hold request to the host. It waits for hold-acknowledge, then grants exactly one channel and drives that channel's acknowledge line. The active level of the acknowledge lines is also programmable.

A grant is never taken away before its service ends. The end of service is signalled by a one-cycle end-of-process strobe. The winner is picked in one of two ways. In fixed order, the lowest channel number wins. In rotating order, the channel served last drops to the bottom of the order. When a service ends, the block drops the hold request and does not raise it again until the host has let hold-acknowledge fall. End-of-process also updates per-channel state: the served channel's mask bit is set unless that channel is marked for automatic reload, and its software request bit is cleared. The block does not generate addresses or bus strobes. It only reports which channel is active and when its service ends.

Top module: `dma_arbiter`

## Requirements
- R1: With `cfg_rotate` low, the granted channel is the lowest-numbered channel with a qualified request.
- R2: With `cfg_rotate` high, the search starts at the channel after the one served last, wrapping from NCH-1 to 0, and the first qualified request found wins. After reset the last-served channel is NCH-1, so channel 0 heads the order.
- R3: Once a channel is granted, `act_vld` stays high and `act_ch` does not change until the cycle in which `eop` is sampled high, whatever the requests do meanwhile.
- R4: Channel i has a qualified request when its software request bit is set, or when its hardware line is at its active level and mask bit i is clear.
- R5: From idle, with `hlda` low and `cfg_disable` low, a qualified request sampled at a clock edge raises `hrq` after that edge. `hrq` then stays high until `hlda` is sampled high, even if every request is withdrawn. If no qualified request exists when `hlda` is sampled, no grant is made and `hrq` falls.
- R6: After a service ends, `hrq` is low and stays low while `hlda` is high. It can rise again only at the edge after the one at which `hlda` is first sampled low.
- R7: Polarity follows the command inputs. `cfg_req_low` = 0 makes the hardware lines active high and 1 makes them active low. `cfg_ack_high` = 0 makes `dack` active low and 1 makes it active high. All-zero command inputs therefore give active-high requests and active-low acknowledges.
- R8: While `cfg_disable` is high, `hrq` is never raised from idle.
- R9: `svc_done` is high in a cycle when a channel is granted and `eop` is high. At the following edge, that channel's software request bit is cleared, and its mask bit is set unless its `autoinit` bit is 1, in which case the mask bit is unchanged.
- R10: The grant is taken at the edge where `hlda` is sampled high while the hold request is pending. `dack` shows the active level only while `act_vld` is high, and only on line `act_ch`. All other lines, and all lines outside a service, show the inactive level.
- R11: After reset, `hrq` and `act_vld` are low, all mask bits are set, all software request bits are clear, and `dack` is inactive.
- R12: The set and clear pulse vectors for the mask and software request bits act at the next edge. Bits not pulsed are unchanged. If set and clear hit the same bit, set wins. End-of-process updates take priority over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hw_req | input | NCH | Hardware request lines, polarity per `cfg_req_low` |
| sw_set | input | NCH | Pulses that set software request bits |
| sw_clr | input | NCH | Pulses that clear software request bits |
| mask_set | input | NCH | Pulses that set mask bits |
| mask_clr | input | NCH | Pulses that clear mask bits |
| autoinit | input | NCH | Per-channel automatic reload mode; keeps the mask bit at end of service |
| cfg_rotate | input | 1 | 1 selects rotating order, 0 selects fixed order |
| cfg_disable | input | 1 | 1 prevents any new service from starting |
| cfg_req_low | input | 1 | 1 makes hardware requests active low |
| cfg_ack_high | input | 1 | 1 makes acknowledges active high |
| hlda | input | 1 | Hold-acknowledge from host |
| eop | input | 1 | End-of-process strobe for the active service |
| hrq | output | 1 | Hold request to host |
| dack | output | NCH | Per-channel acknowledge, polarity per `cfg_ack_high` |
| act_vld | output | 1 | A channel is currently granted |
| act_ch | output | CW | Index of the granted channel |
| svc_done | output | 1 | Service ends this cycle |
| mask_o | output | NCH | Current mask bits |
| swreq_o | output | NCH | Current software request bits |

## Verification
The hardest situations to reach are the ones where the host and the requesters disagree in time. One is a request that disappears while the hold request waits for acknowledge. Another is a request that stays pending while the host is slow to release hold-acknowledge after a service. Directed sequences create both: the request is dropped between `hrq` and `hlda`, and `hlda` is held high for several cycles with another channel still requesting. Rotating order depends on the whole history of services, so the random phase keeps its own record of the last channel served. That phase mixes random masks, software bits, hardware levels and polarities across consecutive services, and a higher-priority request is raised during every grant to test that the grant holds.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HOLD    = 2'd1,
        ST_SERVE   = 2'd2,
        ST_RELEASE = 2'd3
    } arb_state_e;

    // index width for a channel count, never below one bit
    function automatic int chan_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // (a + b) modulo n for a, b already below n
    function automatic int wrap_add(input int a, input int b, input int n);
        int s;
        s = a + b;
        if (s >= n) s = s - n;
        return s;
    endfunction

endpackage

// File: rtl/dma_arb_req_qual.sv
module dma_arb_req_qual
    import dma_arb_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CW = chan_w(NCH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] hw_req,
    input  logic           req_low,
    input  logic [NCH-1:0] sw_set,
    input  logic [NCH-1:0] sw_clr,
    input  logic [NCH-1:0] mask_set,
    input  logic [NCH-1:0] mask_clr,
    input  logic [NCH-1:0] autoinit,
    input  logic           end_hit,
    input  logic [CW-1:0]  end_ch,
    output logic [NCH-1:0] mask_q,
    output logic [NCH-1:0] sw_q,
    output logic [NCH-1:0] valid
);

    logic [NCH-1:0] mask_d;
    logic [NCH-1:0] sw_d;
    logic [NCH-1:0] hw_act;

    always_comb begin
        mask_d = (mask_q & ~mask_clr) | mask_set;
        sw_d   = (sw_q & ~sw_clr) | sw_set;
        if (end_hit) begin
            if (!autoinit[end_ch]) mask_d[end_ch] = 1'b1;
            sw_d[end_ch] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            sw_q   <= '0;
        end else begin
            mask_q <= mask_d;
            sw_q   <= sw_d;
        end
    end

    assign hw_act = hw_req ^ {NCH{req_low}};
    assign valid  = (hw_act & ~mask_q) | sw_q;

    AST_EOP_SW_CLEARED: assert property (@(posedge clk) disable iff (rst)
        end_hit |=> !sw_q[$past(end_ch)]);                                   // R9
    AST_EOP_MASK_SET: assert property (@(posedge clk) disable iff (rst)
        (end_hit && !autoinit[end_ch]) |=> mask_q[$past(end_ch)]);           // R9
    AST_EOP_MASK_KEPT: assert property (@(posedge clk) disable iff (rst)
        (end_hit && autoinit[end_ch] && !mask_set[end_ch] && !mask_clr[end_ch])
        |=> (mask_q[$past(end_ch)] == $past(mask_q[end_ch])));               // R9

endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick
    import dma_arb_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CW = chan_w(NCH)
) (
    input  logic [NCH-1:0] valid,
    input  logic           rotate,
    input  logic [CW-1:0]  last_ch,
    output logic           win_vld,
    output logic [CW-1:0]  win_ch
);

    int start_idx;
    int probe;

    always_comb begin
        win_vld   = 1'b0;
        win_ch    = '0;
        start_idx = 0;
        probe     = 0;
        if (rotate) start_idx = wrap_add(int'(last_ch), 1, NCH);
        for (int off = 0; off < NCH; off++) begin
            probe = wrap_add(start_idx, off, NCH);
            if (!win_vld && valid[probe]) begin
                win_vld = 1'b1;
                win_ch  = CW'(probe);
            end
        end
    end

endmodule

// File: rtl/dma_arb_fsm.sv
module dma_arb_fsm
    import dma_arb_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CW = chan_w(NCH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          any_valid,
    input  logic          disable_i,
    input  logic          hlda,
    input  logic          eop,
    input  logic [CW-1:0] win_ch,
    output logic          hrq,
    output logic          grant_vld,
    output logic [CW-1:0] grant_ch,
    output logic [CW-1:0] last_ch,
    output logic          end_hit
);

    arb_state_e state_q;
    arb_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (any_valid && !disable_i && !hlda) state_d = ST_HOLD;
            ST_HOLD:    if (hlda) state_d = (any_valid && !disable_i) ? ST_SERVE : ST_RELEASE;
            ST_SERVE:   if (eop) state_d = ST_RELEASE;
            ST_RELEASE: if (!hlda) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            grant_ch <= '0;
            last_ch  <= CW'(NCH - 1);
        end else begin
            state_q <= state_d;
            if (state_q == ST_HOLD && state_d == ST_SERVE) grant_ch <= win_ch;
            if (end_hit) last_ch <= grant_ch;
        end
    end

    assign hrq       = (state_q == ST_HOLD) || (state_q == ST_SERVE);
    assign grant_vld = (state_q == ST_SERVE);
    assign end_hit   = grant_vld && eop;

    AST_HRQ_WAITS_HLDA: assert property (@(posedge clk) disable iff (rst)
        (hrq && !grant_vld && !hlda) |=> hrq);                               // R5
    AST_RELEASE_WAIT: assert property (@(posedge clk) disable iff (rst)
        (!hrq && hlda) |=> !hrq);                                            // R6
    AST_DONE_DROPS_HRQ: assert property (@(posedge clk) disable iff (rst)
        end_hit |=> !hrq);                                                   // R6
    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (rst)
        (grant_vld && !eop) |=> (grant_vld && $stable(grant_ch)));           // R3
    AST_DISABLE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (disable_i && !hrq) |=> !hrq);                                       // R8
    AST_GRANT_AFTER_HLDA: assert property (@(posedge clk) disable iff (rst)
        $rose(grant_vld) |-> $past(hlda));                                   // R10

endmodule

// File: rtl/dma_arb_ack.sv
module dma_arb_ack
    import dma_arb_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CW = chan_w(NCH)
) (
    input  logic           grant_vld,
    input  logic [CW-1:0]  grant_ch,
    input  logic           ack_high,
    output logic [NCH-1:0] dack
);

    for (genvar g = 0; g < NCH; g++) begin : g_lane
        logic hit;
        assign hit     = grant_vld && (grant_ch == CW'(g));
        assign dack[g] = ack_high ? hit : !hit;
    end

endmodule

// File: rtl/dma_arbiter.sv
module dma_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CW = chan_w(NCH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] hw_req,
    input  logic [NCH-1:0] sw_set,
    input  logic [NCH-1:0] sw_clr,
    input  logic [NCH-1:0] mask_set,
    input  logic [NCH-1:0] mask_clr,
    input  logic [NCH-1:0] autoinit,
    input  logic           cfg_rotate,
    input  logic           cfg_disable,
    input  logic           cfg_req_low,
    input  logic           cfg_ack_high,
    input  logic           hlda,
    input  logic           eop,
    output logic           hrq,
    output logic [NCH-1:0] dack,
    output logic           act_vld,
    output logic [CW-1:0]  act_ch,
    output logic           svc_done,
    output logic [NCH-1:0] mask_o,
    output logic [NCH-1:0] swreq_o
);

    logic [NCH-1:0] valid;
    logic           win_vld;
    logic [CW-1:0]  win_ch;
    logic [CW-1:0]  last_ch;
    logic           end_hit;
    logic [NCH-1:0] ack_asserted;

    dma_arb_req_qual #(.NCH(NCH)) u_qual (
        .clk      (clk),
        .rst      (rst),
        .hw_req   (hw_req),
        .req_low  (cfg_req_low),
        .sw_set   (sw_set),
        .sw_clr   (sw_clr),
        .mask_set (mask_set),
        .mask_clr (mask_clr),
        .autoinit (autoinit),
        .end_hit  (end_hit),
        .end_ch   (act_ch),
        .mask_q   (mask_o),
        .sw_q     (swreq_o),
        .valid    (valid)
    );

    dma_arb_pick #(.NCH(NCH)) u_pick (
        .valid   (valid),
        .rotate  (cfg_rotate),
        .last_ch (last_ch),
        .win_vld (win_vld),
        .win_ch  (win_ch)
    );

    dma_arb_fsm #(.NCH(NCH)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .any_valid (win_vld),
        .disable_i (cfg_disable),
        .hlda      (hlda),
        .eop       (eop),
        .win_ch    (win_ch),
        .hrq       (hrq),
        .grant_vld (act_vld),
        .grant_ch  (act_ch),
        .last_ch   (last_ch),
        .end_hit   (end_hit)
    );

    dma_arb_ack #(.NCH(NCH)) u_ack (
        .grant_vld (act_vld),
        .grant_ch  (act_ch),
        .ack_high  (cfg_ack_high),
        .dack      (dack)
    );

    assign svc_done     = end_hit;
    assign ack_asserted = cfg_ack_high ? dack : ~dack;

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack_asserted));                                             // R10
    AST_ACK_QUIET: assert property (@(posedge clk) disable iff (rst)
        !act_vld |-> (ack_asserted == '0));                                  // R10
    AST_GRANT_WAS_VALID: assert property (@(posedge clk) disable iff (rst)
        $rose(act_vld) |-> $past(win_vld));                                  // R5

endmodule

// File: tb/dma_arbiter_tb.sv
module dma_arbiter_tb_top;

    localparam int NCH = 4;
    localparam int CW  = 2;
    localparam int WATCHDOG = 20000;

    logic           clk = 1'b0;
    logic           rst;
    logic [NCH-1:0] hw_log;
    logic [NCH-1:0] hw_req;
    logic [NCH-1:0] sw_set, sw_clr, mask_set, mask_clr, autoinit;
    logic           cfg_rotate, cfg_disable, cfg_req_low, cfg_ack_high;
    logic           hlda, eop;
    logic           hrq, act_vld, svc_done;
    logic [NCH-1:0] dack, mask_o, swreq_o;
    logic [CW-1:0]  act_ch;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [NCH-1:0] m_mask, m_sw;
    int             m_last;

    always #5 clk = ~clk;

    assign hw_req = hw_log ^ {NCH{cfg_req_low}};

    dma_arbiter #(.NCH(NCH)) dut_i (
        .clk(clk), .rst(rst), .hw_req(hw_req), .sw_set(sw_set), .sw_clr(sw_clr),
        .mask_set(mask_set), .mask_clr(mask_clr), .autoinit(autoinit),
        .cfg_rotate(cfg_rotate), .cfg_disable(cfg_disable),
        .cfg_req_low(cfg_req_low), .cfg_ack_high(cfg_ack_high),
        .hlda(hlda), .eop(eop), .hrq(hrq), .dack(dack), .act_vld(act_vld),
        .act_ch(act_ch), .svc_done(svc_done), .mask_o(mask_o), .swreq_o(swreq_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            n_bad = n_bad + 1;
            $display("FAIL R5 watchdog: cycles %0d expected below %0d", cyc, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [NCH-1:0] ack_pat(input logic vld, input int ch);
        logic [NCH-1:0] p;
        p = vld ? (NCH'(1) << ch) : '0;
        return cfg_ack_high ? p : ~p;
    endfunction

    function automatic int exp_pick(input logic [NCH-1:0] v, input logic rot, input int last);
        int s;
        s = rot ? ((last + 1) % NCH) : 0;
        for (int k = 0; k < NCH; k++) begin
            if (v[(s + k) % NCH]) return (s + k) % NCH;
        end
        return -1;
    endfunction

    // load mask/software bits and hardware levels from idle; after return the
    // registers hold the new values and the state machine is still idle
    task automatic cfg_load(input logic [NCH-1:0] m, input logic [NCH-1:0] s,
                            input logic [NCH-1:0] h);
        mask_set = m;  mask_clr = ~m;
        sw_set   = s;  sw_clr   = ~s;
        hw_log   = h;
        tick();
        mask_set = '0; mask_clr = '0; sw_set = '0; sw_clr = '0;
        m_mask = m; m_sw = s;
        chk("R12 mask load", 32'(mask_o), 32'(m));
        chk("R12 swreq load", 32'(swreq_o), 32'(s));
        chk("R5 hrq not yet raised", 32'(hrq), 32'd0);
    endtask

    // entered with hrq pending; grants, checks stability, ends the service
    task automatic serve(input string req, input int exp_ch, input logic [NCH-1:0] ai);
        autoinit = ai;
        hlda = 1'b1;
        tick();
        chk("R10 grant after hlda", 32'(act_vld), 32'd1);
        chk(req, 32'(act_ch), 32'(exp_ch));
        chk("R10 dack pattern", 32'(dack), 32'(ack_pat(1'b1, exp_ch)));
        hw_log = '1;
        tick();
        tick();
        chk("R3 grant not preempted", 32'(act_ch), 32'(exp_ch));
        chk("R3 grant still valid", 32'(act_vld), 32'd1);
        chk("R9 no done before eop", 32'(svc_done), 32'd0);
        eop = 1'b1;
        #1;
        chk("R9 done with eop", 32'(svc_done), 32'd1);
        tick();
        eop = 1'b0;
        if (!ai[exp_ch]) m_mask[exp_ch] = 1'b1;
        m_sw[exp_ch] = 1'b0;
        m_last = exp_ch;
        chk("R6 hrq low after service", 32'(hrq), 32'd0);
        chk("R10 no grant after service", 32'(act_vld), 32'd0);
        chk("R10 dack idle after service", 32'(dack), 32'(ack_pat(1'b0, 0)));
        chk("R9 mask after eop", 32'(mask_o), 32'(m_mask));
        chk("R9 swreq after eop", 32'(swreq_o), 32'(m_sw));
    endtask

    // mask everything, drop all requests, release hold-acknowledge
    task automatic cleanup();
        hw_log = '0;
        mask_set = '1; mask_clr = '0; sw_clr = '1; sw_set = '0;
        tick();
        mask_set = '0; sw_clr = '0;
        hlda = 1'b0;
        m_mask = '1; m_sw = '0;
        tick();
        chk("R6 hrq low after cleanup", 32'(hrq), 32'd0);
    endtask

    initial begin
        logic [NCH-1:0] mr, sr, hr, vv;
        int e;
        void'($urandom(32'h5A17));
        rst = 1'b1;
        hw_log = '0; sw_set = '0; sw_clr = '0; mask_set = '0; mask_clr = '0;
        autoinit = '0; cfg_rotate = 0; cfg_disable = 0; cfg_req_low = 0;
        cfg_ack_high = 0; hlda = 0; eop = 0;
        m_mask = '1; m_sw = '0; m_last = NCH - 1;
        tick(); tick();
        rst = 1'b0;
        tick();

        // reset state
        chk("R11 hrq", 32'(hrq), 32'd0);
        chk("R11 act_vld", 32'(act_vld), 32'd0);
        chk("R11 mask all set", 32'(mask_o), 32'hF);
        chk("R11 swreq clear", 32'(swreq_o), 32'd0);
        chk("R11 dack inactive low-active", 32'(dack), 32'hF);
        hw_log = 4'b0001;
        tick();
        chk("R4 masked hardware request ignored", 32'(hrq), 32'd0);
        hw_log = '0;

        // disable holds off service
        cfg_disable = 1'b1;
        cfg_load('0, '0, 4'b0100);
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R8 disabled no hrq", 32'(hrq), 32'd0);
        end
        cfg_disable = 1'b0;
        tick();
        chk("R5 hrq raised", 32'(hrq), 32'd1);
        serve("R1 single request", 2, '0);
        cleanup();

        // request withdrawn while waiting for hold-acknowledge
        cfg_load('0, '0, 4'b1000);
        tick();
        chk("R5 hrq raised", 32'(hrq), 32'd1);
        hw_log = '0;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R5 hrq held without request", 32'(hrq), 32'd1);
        end
        hlda = 1'b1;
        tick();
        chk("R5 no grant without request", 32'(act_vld), 32'd0);
        chk("R5 hrq falls", 32'(hrq), 32'd0);
        cleanup();

        // fixed order and release handshake
        cfg_load('0, '0, 4'b1010);
        tick();
        chk("R5 hrq raised", 32'(hrq), 32'd1);
        serve("R1 fixed lowest wins", 1, '0);
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R6 hrq waits for hlda low", 32'(hrq), 32'd0);
        end
        hlda = 1'b0;
        tick();
        chk("R6 idle edge keeps hrq low", 32'(hrq), 32'd0);
        tick();
        chk("R6 hrq after release", 32'(hrq), 32'd1);
        serve("R1 fixed after mask update", 0, 4'b0001);
        chk("R9 autoinit keeps mask bit", 32'(mask_o[0]), 32'd0);
        cleanup();

        // software request bypasses mask
        cfg_load('1, 4'b0100, '0);
        tick();
        chk("R4 software request raises hrq", 32'(hrq), 32'd1);
        serve("R4 software request granted", 2, '0);
        cleanup();

        // rotating order: last served 2, so 3,0,1,2
        cfg_rotate = 1'b1;
        cfg_load('0, '0, 4'b0101);
        tick();
        chk("R5 hrq raised", 32'(hrq), 32'd1);
        serve("R2 rotating after channel 2", 0, '0);
        cleanup();

        // inverted polarities
        cfg_rotate = 1'b0; cfg_req_low = 1'b1; cfg_ack_high = 1'b1;
        tick();
        chk("R7 dack idle active-high", 32'(dack), 32'h0);
        cfg_load('0, '0, 4'b0100);
        tick();
        chk("R7 active-low request seen", 32'(hrq), 32'd1);
        serve("R7 active-low request granted", 2, '0);
        cleanup();

        // set beats clear on the same bit
        cfg_disable = 1'b1;
        mask_clr = 4'b0011; mask_set = 4'b0001;
        sw_set = 4'b0010; sw_clr = 4'b0010;
        tick();
        mask_clr = '0; mask_set = '0; sw_set = '0; sw_clr = '0;
        chk("R12 mask set wins", 32'(mask_o), 32'b1101);
        chk("R12 swreq set wins", 32'(swreq_o), 32'b0010);
        cleanup();
        chk("R12 swreq cleared", 32'(swreq_o), 32'd0);
        cfg_disable = 1'b0;

        // random services
        for (int it = 0; it < 60; it++) begin
            cfg_rotate   = 1'($urandom % 2);
            cfg_req_low  = 1'($urandom % 2);
            cfg_ack_high = 1'($urandom % 2);
            mr = NCH'($urandom); sr = NCH'($urandom); hr = NCH'($urandom);
            if (it % 4 == 0) sr = '0;
            vv = (hr & ~mr) | sr;
            cfg_load(mr, sr, hr);
            tick();
            if (vv == '0) begin
                chk("R4 no qualified request no hrq", 32'(hrq), 32'd0);
            end else begin
                chk("R5 hrq raised", 32'(hrq), 32'd1);
                e = exp_pick(vv, cfg_rotate, m_last);
                serve(cfg_rotate ? "R2 rotating winner" : "R1 fixed winner",
                      e, NCH'($urandom));
            end
            cleanup();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule